// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a register-mapped SPI master that works through a short list of transfers on its own. Software loads up to sixteen transmit words and sixteen per-word command entries through an address register and a data port. The address moves forward by one on every data-port access. Software then sets a run bit, and the controller shifts each listed word out on `mosi` while taking a word in on `miso`. Each received word goes into a receive memory at the same index as the word that was sent.

The sequencer starts at a programmed first entry and steps forward, modulo sixteen, until it has finished a programmed last entry. It then clears the run bit by itself and sets a completion flag. With wrapping enabled it instead goes back to the first entry and keeps running, and it sets a wrap flag each time it does so. Software stops a running list by writing the run bit to zero.

A per-entry command selects the word width and whether chip select is held into the next word. The mode register sets the programmed width, the clock polarity, the clock phase and the divisor. Chip-select pins are outside this block, which only reports when a select should be active.

Top module: `qspi_queue_ctrl`

## Requirements
- R1: After reset every register reads zero, and `sck`, `cs_assert` and `irq` are low.
- R2: Register word 4 (byte offset 0x10) holds a 6-bit memory address. Data-port word 5 (byte offset 0x14) reaches the following regions: transmit memory at 0x00-0x0F, receive memory at 0x10-0x1F and command memory at 0x20-0x2F. Addresses from 0x30 up read zero. Each data-port read or write adds one to the address. Command entries keep only bits 15:14 and read the other bits as zero.
- R3: Writing bit 15 of register word 1 (byte offset 0x04) starts the list, but only when bit 15 of the mode register (word 0) is set. While the list runs, bit 15 reads one. It clears itself when the list ends, and a start written while master enable is clear is ignored.
- R4: Words are shifted most significant bit first. The low W bits of a transmit entry appear on `mosi`, and receive entry i holds the W bits taken in during entry i, right-justified, with the upper bits zero.
- R5: Command bit 14 clear selects an 8-bit word. When it is set, the width comes from mode bits 13:10: a value of 0 gives 16 bits and a value from 8 to 15 gives that many bits.
- R6: Mode bit 9 (CPOL) is the idle level of `sck`. With mode bit 8 (CPHA) clear, `miso` is sampled on the leading edge. With CPHA set, `miso` is sampled on the trailing edge, and `mosi` never changes on a sampling edge.
- R7: Each `sck` half period lasts the number of clock cycles given by divisor mode bits 7:0. A word keeps `cs_assert` high for divisor×(2W+1) cycles. With a divisor of 0 the list stalls with no `sck` edges.
- R8: When command bit 15 of an entry is set and the list goes on, `cs_assert` stays high into the next word. Otherwise it drops for one half period between words, and it always drops at the end of the list.
- R9: Word 3 (byte offset 0x0C) holds flags at bit 0 (done), bit 2 (abort) and bit 3 (wrap), with matching enables at bits 8, 10 and 11. Writing 1 to a flag clears it. `irq` is high while any flag and its enable are both set. The done flag is set when a list ends normally.
- R10: Register word 2 (byte offset 0x08) holds the first entry in bits 3:0, the last entry in bits 11:8 and wrap enable at bit 14. With wrap enabled, the list returns to the first entry after the last one, sets the wrap flag, and bit 15 of word 1 stays set.
- R11: Writing word 1 with bit 15 clear while the list runs stops it at once. `sck` returns to its idle level, `cs_assert` drops, the abort flag is set, the run bit clears and the done flag is not set.
- R12: The entry pointer starts at the first entry and steps by one modulo 16, so a list can pass from entry 15 to entry 0.
- R13: While the list runs, mode-register writes are ignored. Writes to word 2 are stored, but they take effect only at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_cs | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word index (byte address bits 4:2) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid during the access cycle |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_assert | output | 1 | High while a slave should be selected |

## Verification
The bench goes after mixed word widths in one list, where the 16-bit encoding of width field 0 matters. A design that misread that encoding, or took the width from the wrong entry, would shift the wrong number of bits and put wrongly aligned words into the receive memory. The bench covers all four clock modes against a slave model that changes its data only on the edges that modes allow, so sampling on the wrong edge shows up as corrupted receive words. It also checks:
- that the select is held or dropped between words exactly as each command entry says, so a missing gap or an extra gap changes the count of select pulses;
- pointer wrap from 15 to 0;
- wrap-mode restart followed by an immediate abort, where a wrong design would leave the run bit set or report completion;
- that writes to the mode and pointer registers during a run leave the running list intact.

// File: rtl/qspi_queue_ctrl.sv
module qspi_queue_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_cs,
  input  logic        reg_we,
  input  logic [4:2]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_assert
);

  localparam int ENTRIES = 16;
  localparam int PW      = $clog2(ENTRIES);
  localparam int DW      = 16;
  localparam int LW      = $clog2(DW) + 1;
  localparam int EW      = LW + 1;
  localparam logic [DW-1:0] MODE_MASK = 16'hBFFF;
  localparam logic [DW-1:0] WRAP_MASK = 16'hDF0F;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  logic [DW-1:0] tx_mem  [ENTRIES];
  logic [DW-1:0] rx_mem  [ENTRIES];
  logic [1:0]    cmd_mem [ENTRIES];

  logic [DW-1:0] mode_q, wrap_q, sh;
  logic [5:0]    ram_adr;
  logic          run_q, spif, abrt, wcef, en_spif, en_abrt, en_wcef;
  st_t           st;
  logic [PW-1:0] ptr, q_end, q_new;
  logic          q_wrap, cont_q, rbit, sck_q;
  logic [7:0]    hc;
  logic [EW-1:0] ecnt;
  logic [LW-1:0] wlen;

  logic       wr_en, port_acc, start_req, abort_req, tick, last, word_done, ending;
  logic [7:0] baud;
  logic       cpol, cpha;
  logic [3:0] bits;
  logic [PW-1:0] nxt_ptr, ld_idx;
  logic          ld_en;
  logic [LW-1:0] ld_w;
  logic [DW-1:0] ld_data, cap_word, ram_rd;

  function automatic logic [LW-1:0] width_of(input logic bitse, input logic [3:0] b);
    if (!bitse)        return LW'(8);
    else if (b == 4'd0) return LW'(16);
    else               return LW'(b);
  endfunction

  assign wr_en     = reg_cs & reg_we;
  assign port_acc  = reg_cs && (reg_addr == 3'd5);
  assign baud      = mode_q[7:0];
  assign cpol      = mode_q[9];
  assign cpha      = mode_q[8];
  assign bits      = mode_q[13:10];
  assign start_req = wr_en && reg_addr == 3'd1 && reg_wdata[15] && !run_q && mode_q[15];
  assign abort_req = wr_en && reg_addr == 3'd1 && !reg_wdata[15] && run_q;
  assign tick      = (st != S_IDLE) && (baud != 8'd0) && (hc == baud - 8'd1);
  assign last      = (ptr == q_end);
  assign word_done = (st == S_SHIFT) && tick && (ecnt == {wlen, 1'b0});
  assign ending    = word_done && last && !q_wrap;
  assign nxt_ptr   = last ? q_new : ptr + PW'(1);
  assign cap_word  = (cpha ? {sh[DW-2:0], rbit} : sh) & (16'hFFFF >> (LW'(DW) - wlen));

  always_comb begin
    ld_en  = 1'b0;
    ld_idx = ptr;
    if (start_req) begin
      ld_en  = 1'b1;
      ld_idx = wrap_q[PW-1:0];
    end else if (word_done && !ending && cont_q) begin
      ld_en  = 1'b1;
      ld_idx = nxt_ptr;
    end else if (st == S_GAP && tick) begin
      ld_en  = 1'b1;
    end
  end

  assign ld_w    = width_of(cmd_mem[ld_idx][0], bits);
  assign ld_data = tx_mem[ld_idx] << (LW'(DW) - ld_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      run_q  <= 1'b0;
      ptr    <= '0;
      q_end  <= '0;
      q_new  <= '0;
      q_wrap <= 1'b0;
      hc     <= '0;
      ecnt   <= '0;
      wlen   <= LW'(8);
      cont_q <= 1'b0;
      sh     <= '0;
      rbit   <= 1'b0;
      sck_q  <= 1'b0;
    end else if (abort_req) begin
      st    <= S_IDLE;
      run_q <= 1'b0;
      sck_q <= cpol;
    end else begin
      case (st)
        S_IDLE: begin
          sck_q <= cpol;
          if (start_req) begin
            run_q  <= 1'b1;
            st     <= S_SHIFT;
            ptr    <= wrap_q[PW-1:0];
            q_new  <= wrap_q[PW-1:0];
            q_end  <= wrap_q[PW+7:8];
            q_wrap <= wrap_q[14];
          end
        end
        S_SHIFT: begin
          if (baud != 8'd0) hc <= tick ? 8'd0 : hc + 8'd1;
          if (tick && !word_done) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + EW'(1);
            if (~ecnt[0] ^ cpha) rbit <= miso;
            else if (ecnt != '0) sh <= {sh[DW-2:0], rbit};
          end
          if (word_done) begin
            if (ending) begin
              st    <= S_IDLE;
              run_q <= 1'b0;
            end else begin
              ptr <= nxt_ptr;
              if (!cont_q) st <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (baud != 8'd0) hc <= tick ? 8'd0 : hc + 8'd1;
          if (tick) st <= S_SHIFT;
        end
        default: st <= S_IDLE;
      endcase
      if (ld_en) begin
        sh     <= ld_data;
        wlen   <= ld_w;
        cont_q <= cmd_mem[ld_idx][1];
        hc     <= '0;
        ecnt   <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (word_done && !abort_req) rx_mem[ptr] <= cap_word;
    if (port_acc && reg_we && ram_adr[5:4] == 2'd0) tx_mem[ram_adr[3:0]] <= reg_wdata;
    if (port_acc && reg_we && ram_adr[5:4] == 2'd2) cmd_mem[ram_adr[3:0]] <= reg_wdata[15:14];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      wrap_q  <= '0;
      ram_adr <= '0;
      spif    <= 1'b0;
      abrt    <= 1'b0;
      wcef    <= 1'b0;
      en_spif <= 1'b0;
      en_abrt <= 1'b0;
      en_wcef <= 1'b0;
    end else begin
      if (wr_en && reg_addr == 3'd0 && !run_q) mode_q <= reg_wdata & MODE_MASK;
      if (wr_en && reg_addr == 3'd2) wrap_q <= reg_wdata & WRAP_MASK;
      if (wr_en && reg_addr == 3'd4) ram_adr <= reg_wdata[5:0];
      else if (port_acc)             ram_adr <= ram_adr + 6'd1;
      if (wr_en && reg_addr == 3'd3) begin
        en_spif <= reg_wdata[8];
        en_abrt <= reg_wdata[10];
        en_wcef <= reg_wdata[11];
        spif    <= (spif & ~reg_wdata[0]) | (ending && !abort_req);
        abrt    <= (abrt & ~reg_wdata[2]) | abort_req;
        wcef    <= (wcef & ~reg_wdata[3]) | (word_done && last && q_wrap && !abort_req);
      end else begin
        spif <= spif | (ending && !abort_req);
        abrt <= abrt | abort_req;
        wcef <= wcef | (word_done && last && q_wrap && !abort_req);
      end
    end
  end

  always_comb begin
    case (ram_adr[5:4])
      2'd0:    ram_rd = tx_mem[ram_adr[3:0]];
      2'd1:    ram_rd = rx_mem[ram_adr[3:0]];
      2'd2:    ram_rd = {cmd_mem[ram_adr[3:0]], 14'd0};
      default: ram_rd = '0;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_cs && !reg_we) begin
      case (reg_addr)
        3'd0: reg_rdata = mode_q;
        3'd1: reg_rdata = {run_q, 15'd0};
        3'd2: reg_rdata = wrap_q;
        3'd3: reg_rdata = {4'd0, en_wcef, en_abrt, 1'b0, en_spif, 4'd0, wcef, abrt, 1'b0, spif};
        3'd4: reg_rdata = {10'd0, ram_adr};
        3'd5: reg_rdata = ram_rd;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq       = (spif & en_spif) | (abrt & en_abrt) | (wcef & en_wcef);
  assign sck       = sck_q;
  assign mosi      = sh[DW-1];
  assign cs_assert = (st == S_SHIFT);

  AST_CS_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n) cs_assert |-> run_q); // R3
  AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) $fell(run_q) |-> (spif || abrt)); // R9
  AST_WRAP_RUNS: assert property (@(posedge clk) disable iff (!rst_n) $rose(wcef) |-> run_q); // R10
  AST_START_PTR: assert property (@(posedge clk) disable iff (!rst_n) $rose(run_q) |-> ptr == $past(wrap_q[PW-1:0])); // R12
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (run_q && $past(run_q)) |-> $stable(mode_q)); // R13
  AST_STALL_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (run_q && baud == 8'd0) |=> $stable(sck)); // R7
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cs_assert |-> ecnt <= {wlen, 1'b0}); // R7

endmodule

// File: tb/qspi_queue_ctrl_tb.sv
module qspi_queue_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_cs = 1'b0, reg_we = 1'b0;
  logic [4:2] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq, sck, mosi, cs_assert;
  logic miso = 1'b0;

  qspi_queue_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_assert(cs_assert));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit slv_on = 0, cpol_b = 0, cpha_b = 0;
  int sidx = 0, capn = 0, sck_edges = 0, cs_rises = 0, cs_hi = 0;
  bit cap [0:1023];
  logic [15:0] q_tx [16];
  logic [15:0] q_cmd [16];

  function automatic bit sbit(input int k);
    return ((k * 13 + k / 5) % 7) < 3;
  endfunction

  always @(sck) if (slv_on) begin
    sck_edges++;
    if (!cpha_b) begin
      if (sck != cpol_b) begin cap[capn] = mosi; capn++; end
      else begin sidx++; miso = sbit(sidx); end
    end else begin
      if (sck != cpol_b) begin miso = sbit(sidx); sidx++; end
      else begin cap[capn] = mosi; capn++; end
    end
  end
  always @(posedge cs_assert) cs_rises++;
  always @(negedge clk) if (cs_assert) cs_hi++;

  task automatic chk(input string tg, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tg, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_cs = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_cs = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_cs = 0;
  endtask

  task automatic wait_idle(input string tg);
    logic [15:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd1, v);
      if (!v[15]) return;
    end
    chk(tg, "run bit never cleared", 1, 0);
  endtask

  task automatic slave_arm(input logic [15:0] modev);
    @(negedge clk);
    cpol_b = modev[9]; cpha_b = modev[8];
    sidx = 0; capn = 0; sck_edges = 0; cs_rises = 0; cs_hi = 0;
    miso = sbit(0);
    slv_on = 1;
  endtask

  function automatic int exp_w(input logic [15:0] c, input logic [15:0] m);
    if (!c[14]) return 8;
    return (m[13:10] == 0) ? 16 : int'(m[13:10]);
  endfunction

  task automatic do_queue(input logic [15:0] modev, input logic [15:0] wrapv, input int nw,
                          input string tg, input bit meddle);
    logic [15:0] v, e;
    logic [15:0] rxv [16];
    int off, mism, idx, w;
    slv_on = 0;
    wr(3'd0, modev);
    wr(3'd2, wrapv);
    wr(3'd4, 16'h0000);
    for (int i = 0; i < 16; i++) wr(3'd5, q_tx[i]);
    wr(3'd4, 16'h0020);
    for (int i = 0; i < 16; i++) wr(3'd5, q_cmd[i]);
    wr(3'd3, 16'h0D0D);
    slave_arm(modev);
    wr(3'd1, 16'h8000);
    rd(3'd1, v);
    chk("R3", "run bit after start", int'(v[15]), 1);
    if (meddle) begin
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h0000);
    end
    wait_idle(tg);
    slv_on = 0;
    wr(3'd4, 16'h0010);
    for (int i = 0; i < 16; i++) begin rd(3'd5, v); rxv[i] = v; end
    off = 0; mism = 0;
    for (int j = 0; j < nw; j++) begin
      idx = (int'(wrapv[3:0]) + j) % 16;
      w = exp_w(q_cmd[idx], modev);
      e = 0;
      for (int b = 0; b < w; b++) begin
        e[w-1-b] = sbit(off + b);
        if (cap[off + b] != q_tx[idx][w-1-b]) mism++;
      end
      chk(tg, $sformatf("rx entry %0d", idx), int'(rxv[idx]), int'(e));
      off += w;
    end
    chk(tg, "mosi bit count", capn, off);
    chk(tg, "mosi bit mismatches", mism, 0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1", $sformatf("reg %0d after reset", a), int'(v), 0);
    end
    chk("R1", "sck/cs/irq after reset", int'({sck, cs_assert, irq}), 0);
  endtask

  task automatic t_ramport;
    logic [15:0] v;
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h1111); wr(3'd5, 16'h2222); wr(3'd5, 16'h3333);
    rd(3'd4, v); chk("R2", "address after 3 writes", int'(v), 3);
    wr(3'd4, 16'h0000);
    rd(3'd5, v); chk("R2", "tx0", int'(v), 16'h1111);
    rd(3'd5, v); chk("R2", "tx1", int'(v), 16'h2222);
    rd(3'd5, v); chk("R2", "tx2", int'(v), 16'h3333);
    wr(3'd4, 16'h0020); wr(3'd5, 16'hFFFF);
    wr(3'd4, 16'h0020); rd(3'd5, v); chk("R2", "cmd keeps 15:14", int'(v), 16'hC000);
    wr(3'd4, 16'h0030); rd(3'd5, v); chk("R2", "unmapped reads 0", int'(v), 0);
    rd(3'd4, v); chk("R2", "address after read", int'(v), 16'h0031);
  endtask

  task automatic t_basic;
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin q_tx[i] = 16'hA5C3 ^ 16'(i * 16'h1357); q_cmd[i] = 16'h0000; end
    do_queue(16'h8002, 16'h0300, 4, "R4", 0);
    rd(3'd3, v); chk("R9", "done flag set", int'(v[3:0]), 1);
    chk("R9", "irq with done enabled", int'(irq), 1);
    wr(3'd3, 16'h0D01);
    rd(3'd3, v); chk("R9", "done flag cleared", int'(v[0]), 0);
    chk("R9", "irq after clear", int'(irq), 0);
  endtask

  task automatic t_widths;
    q_cmd[0] = 16'h4000; q_cmd[1] = 16'h0000; q_cmd[2] = 16'hC000; q_cmd[3] = 16'h4000;
    do_queue(16'h8000 | (16'd12 << 10) | 16'd2, 16'h0300, 4, "R5", 0);
    q_cmd[0] = 16'h4000; q_cmd[1] = 16'hC000; q_cmd[2] = 16'h0000;
    do_queue(16'h8002, 16'h0200, 3, "R5", 0);
  endtask

  task automatic t_modes;
    for (int m = 1; m < 4; m++) begin
      q_cmd[0] = 16'h4000; q_cmd[1] = 16'h0000; q_cmd[2] = 16'h4000;
      do_queue(16'h8000 | 16'(m << 8) | (16'd10 << 10) | 16'd2, 16'h0200, 3, "R6", 0);
      chk("R6", $sformatf("sck idle level mode %0d", m), int'(sck), (m >> 1) & 1);
    end
  endtask

  task automatic t_timing;
    for (int i = 0; i < 16; i++) q_cmd[i] = 16'h0000;
    do_queue(16'h8003, 16'h0000, 1, "R7", 0);
    chk("R7", "cs cycles one 8-bit word div 3", cs_hi, 51);
    chk("R7", "sck edges one 8-bit word", sck_edges, 16);
  endtask

  task automatic t_cont;
    q_cmd[0] = 16'h8000; q_cmd[1] = 16'h0000; q_cmd[2] = 16'h0000;
    do_queue(16'h8003, 16'h0200, 3, "R8", 0);
    chk("R8", "select pulses with hold on first", cs_rises, 2);
    chk("R8", "cs cycles three words", cs_hi, 153);
    chk("R8", "cs low at end", int'(cs_assert), 0);
  endtask

  task automatic t_ptrwrap;
    for (int i = 0; i < 16; i++) q_cmd[i] = 16'h0000;
    do_queue(16'h8002, 16'h010E, 4, "R12", 0);
  endtask

  task automatic t_meddle;
    logic [15:0] v;
    do_queue(16'h8002, 16'h0300, 4, "R13", 1);
    rd(3'd0, v); chk("R13", "mode write ignored while running", int'(v), 16'h8002);
    rd(3'd2, v); chk("R13", "pointer reg stored", int'(v), 0);
  endtask

  task automatic t_wrap_abort;
    logic [15:0] v;
    bit seen = 0;
    slv_on = 0;
    wr(3'd0, 16'h8302);
    wr(3'd2, 16'h4100);
    wr(3'd3, 16'h040D);
    slave_arm(16'h8302);
    wr(3'd1, 16'h8000);
    for (int i = 0; i < 2000 && !seen; i++) begin rd(3'd3, v); seen = v[3]; end
    chk("R10", "wrap flag seen", int'(seen), 1);
    rd(3'd1, v); chk("R10", "run stays set on wrap", int'(v[15]), 1);
    wr(3'd1, 16'h0000);
    chk("R11", "cs low after abort", int'(cs_assert), 0);
    chk("R11", "sck idle after abort", int'(sck), 1);
    rd(3'd1, v); chk("R11", "run clear after abort", int'(v[15]), 0);
    rd(3'd3, v); chk("R11", "abort set, done clear", int'({v[2], v[0]}), 2);
    chk("R9", "irq from abort enable", int'(irq), 1);
    slv_on = 0;
  endtask

  task automatic t_gate_stall;
    logic [15:0] v;
    wr(3'd3, 16'h000D);
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h8000);
    rd(3'd1, v); chk("R3", "start ignored without master", int'(v[15]), 0);
    wr(3'd0, 16'h8000);
    wr(3'd2, 16'h0000);
    slave_arm(16'h8000);
    wr(3'd1, 16'h8000);
    repeat (100) @(negedge clk);
    rd(3'd1, v); chk("R7", "stalled list still running", int'(v[15]), 1);
    chk("R7", "no sck edges at divisor 0", sck_edges, 0);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk("R11", "abort ends stalled list", int'(v[15]), 0);
    slv_on = 0;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ramport();
    t_basic();
    t_widths();
    t_modes();
    t_timing();
    t_cont();
    t_ptrwrap();
    t_meddle();
    t_wrap_abort();
    t_gate_stall();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule